// File: doc/BRIEF.md
# Configuration Space Bus Router

This block steers configuration accesses to a destination node and link. It has four programmable region registers, each 32 bits wide. Each region holds an inclusive 8-bit window with a lower and an upper bound, read and write permission bits, a compare-mode bit, and the node and link to route to. A region set to bus mode compares the incoming bus number against its window. A region set to device mode compares the device number against its window, and only for accesses to bus 0.

The lookup path is combinational, from the access inputs to `hit`, `destNode` and `destLink`. Region registers are loaded through a simple indexed write port, and the new value takes effect on the cycle after the write. The selected register can be read back on `regRdata`. When several regions match, the one with the lowest index wins. Producing the configuration cycles themselves and decoding function numbers are handled elsewhere.

Top module: `cfg_bus_router`

## Requirements
- R1: After reset every region register reads back as 0x00000000 and no access hits.
- R2: A write with `regWe`=1 loads `regWdata` into the register chosen by `regIdx` at the next rising clock edge, and leaves every other register unchanged.
- R3: With bit 2 = 0 (bus mode), a region matches when lower bound (bits [23:16]) <= `busNum` <= upper bound (bits [31:24]). Both bounds are inclusive.
- R4: With bit 2 = 1 (device mode), a region matches only when `busNum` is 0 and the lower bound <= `devNum` <= the upper bound. An access to any nonzero bus never matches that region.
- R5: A read access (`accWrite`=0) can match a region only if the region's bit 0 is 1. A write access (`accWrite`=1) can match a region only if the region's bit 1 is 1.
- R6: On a hit, `destNode` equals bits [6:4] and `destLink` equals bits [9:8] of the winning region.
- R7: When more than one region matches, the region with the lowest index wins.
- R8: When no region matches, `hit`, `destNode` and `destLink` are all 0.
- R9: A region whose lower bound is greater than its upper bound never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Region register write strobe |
| regIdx | input | 2 | Region register index for write and readback |
| regWdata | input | 32 | Region register write data |
| regRdata | output | 32 | Contents of the register selected by `regIdx` |
| busNum | input | 8 | Bus number of the access |
| devNum | input | 5 | Device number of the access |
| accWrite | input | 1 | Access type: 1 = write, 0 = read |
| hit | output | 1 | Some region matches the access |
| destNode | output | 3 | Destination node of the winning region |
| destLink | output | 2 | Destination link of the winning region |

## Verification
The bench builds the block with its default of four regions, an 8-bit bus number and a 5-bit device number. With these defaults the whole access space is small: 256 bus numbers, 32 device numbers and 2 access types. For one mixed programming the bench sweeps every combination of the three, so every bound, the bus-0 restriction of device mode, the permission bits, the empty window and every overlap can be checked against an arithmetic model of the requirements.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;
  localparam int REGIONS      = 4;
  localparam int IDX_W        = $clog2(REGIONS);
  localparam int REG_W        = 32;
  localparam int BOUND_W      = 8;
  localparam int DEV_W        = 5;
  localparam int NODE_W       = 3;
  localparam int LINK_W       = 2;
  localparam int RD_EN_BIT    = 0;
  localparam int WR_EN_BIT    = 1;
  localparam int DEV_MODE_BIT = 2;
  localparam int NODE_LSB     = 4;
  localparam int LINK_LSB     = 8;
  localparam int LO_LSB       = 16;
  localparam int HI_LSB       = 24;

  typedef struct packed {
    logic [REGIONS-1:0] load;
    logic [REGIONS-1:0] pick;
    logic               anyPick;
  } routeStrobes_t;
endpackage

// File: rtl/cfg_router_ctrl.sv
module cfg_router_ctrl
  import cfg_router_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [IDX_W-1:0]    regIdx,
  input  logic [REGIONS-1:0]  matchVec,
  output routeStrobes_t       strobes
);
  always_comb begin
    strobes = '0;
    for (int i = 0; i < REGIONS; i++) begin
      strobes.load[i] = regWe && (regIdx == IDX_W'(i));
    end
    for (int i = REGIONS - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        strobes.pick = '0;
        strobes.pick[i] = 1'b1;
      end
    end
    strobes.anyPick = |strobes.pick;
  end

  // R7: at most one region is selected
  assert_single_pick_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.pick));

  // R7: the selected region is the lowest matching one
  generate
    for (genvar g = 1; g < REGIONS; g++) begin : gLow
      assert_lowest_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
        (strobes.pick[g] |-> (matchVec[g-1:0] == '0)));
    end
  endgenerate

  // R2: a write loads exactly one register
  assert_single_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> $onehot(strobes.load));
endmodule

// File: rtl/cfg_router_dp.sv
module cfg_router_dp
  import cfg_router_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  routeStrobes_t       strobes,
  input  logic [REG_W-1:0]    regWdata,
  input  logic [IDX_W-1:0]    regIdx,
  input  logic [BOUND_W-1:0]  busNum,
  input  logic [DEV_W-1:0]    devNum,
  input  logic                accWrite,
  output logic [REGIONS-1:0]  matchVec,
  output logic [REG_W-1:0]    regRdata,
  output logic                hit,
  output logic [NODE_W-1:0]   destNode,
  output logic [LINK_W-1:0]   destLink
);
  logic [REG_W-1:0] cfgReg [REGIONS];

  generate
    for (genvar g = 0; g < REGIONS; g++) begin : gRegion
      logic [BOUND_W-1:0] loBound, hiBound, key;
      logic               devMode, permitted, busOk;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                cfgReg[g] <= '0;
        else if (strobes.load[g]) cfgReg[g] <= regWdata;
      end

      always_comb begin
        loBound   = cfgReg[g][LO_LSB +: BOUND_W];
        hiBound   = cfgReg[g][HI_LSB +: BOUND_W];
        devMode   = cfgReg[g][DEV_MODE_BIT];
        permitted = accWrite ? cfgReg[g][WR_EN_BIT] : cfgReg[g][RD_EN_BIT];
        key       = devMode ? BOUND_W'(devNum) : busNum;
        busOk     = !devMode || (busNum == '0);
        matchVec[g] = permitted && busOk && (key >= loBound) && (key <= hiBound);
      end

      assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
        $rose(rstN) |-> (cfgReg[g] == '0));
      assert_load_value_R2: assert property (@(posedge clk) disable iff (!rstN)
        strobes.load[g] |=> (cfgReg[g] == $past(regWdata)));
      assert_hold_other_R2: assert property (@(posedge clk) disable iff (!rstN)
        !strobes.load[g] |=> $stable(cfgReg[g]));
      assert_dev_bus0_R4: assert property (@(posedge clk) disable iff (!rstN)
        (matchVec[g] && devMode) |-> (busNum == '0));
      assert_permit_R5: assert property (@(posedge clk) disable iff (!rstN)
        strobes.pick[g] |-> (accWrite ? cfgReg[g][WR_EN_BIT] : cfgReg[g][RD_EN_BIT]));
      assert_empty_range_R9: assert property (@(posedge clk) disable iff (!rstN)
        matchVec[g] |-> (loBound <= hiBound));
    end
  endgenerate

  always_comb begin
    destNode = '0;
    destLink = '0;
    for (int i = 0; i < REGIONS; i++) begin
      if (strobes.pick[i]) begin
        destNode = destNode | cfgReg[i][NODE_LSB +: NODE_W];
        destLink = destLink | cfgReg[i][LINK_LSB +: LINK_W];
      end
    end
    hit      = strobes.anyPick;
    regRdata = cfgReg[regIdx];
  end

  assert_no_match_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (destNode == '0 && destLink == '0));
endmodule

// File: rtl/cfg_bus_router.sv
module cfg_bus_router
  import cfg_router_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [IDX_W-1:0]   regIdx,
  input  logic [REG_W-1:0]   regWdata,
  output logic [REG_W-1:0]   regRdata,
  input  logic [BOUND_W-1:0] busNum,
  input  logic [DEV_W-1:0]   devNum,
  input  logic               accWrite,
  output logic               hit,
  output logic [NODE_W-1:0]  destNode,
  output logic [LINK_W-1:0]  destLink
);
  routeStrobes_t      strobes;
  logic [REGIONS-1:0] matchVec;

  cfg_router_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regIdx   (regIdx),
    .matchVec (matchVec),
    .strobes  (strobes)
  );

  cfg_router_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .regWdata (regWdata),
    .regIdx   (regIdx),
    .busNum   (busNum),
    .devNum   (devNum),
    .accWrite (accWrite),
    .matchVec (matchVec),
    .regRdata (regRdata),
    .hit      (hit),
    .destNode (destNode),
    .destLink (destLink)
  );
endmodule

// File: tb/cfg_bus_router_bench.sv
module cfg_bus_router_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regIdx = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [7:0]  busNum = '0;
  logic [4:0]  devNum = '0;
  logic        accWrite = 1'b0;
  logic        hit;
  logic [2:0]  destNode;
  logic [1:0]  destLink;

  int checks = 0;
  int errors = 0;
  logic [31:0] shadow [4];

  always #10 clk = ~clk;

  cfg_bus_router u_cfg_bus_router (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regIdx(regIdx),
    .regWdata(regWdata), .regRdata(regRdata), .busNum(busNum),
    .devNum(devNum), .accWrite(accWrite), .hit(hit),
    .destNode(destNode), .destLink(destLink)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // winning region index per the requirements, or -1
  function automatic int winner(input logic [7:0] b, input logic [4:0] d, input logic w);
    for (int i = 0; i < 4; i++) begin
      logic [31:0] r = shadow[i];
      logic en = w ? r[1] : r[0];
      logic [7:0] key = r[2] ? {3'b000, d} : b;
      logic ok = r[2] ? (b == 8'd0) : 1'b1;
      if (en && ok && key >= r[23:16] && key <= r[31:24]) return i;
    end
    return -1;
  endfunction

  task automatic wrReg(input int idx, input logic [31:0] val);
    @(negedge clk);
    regWe = 1'b1; regIdx = 2'(idx); regWdata = val;
    @(negedge clk);
    regWe = 1'b0;
    shadow[idx] = val;
  endtask

  task automatic probe(input string tag, input logic [7:0] b, input logic [4:0] d,
                       input logic w, input logic [5:0] exp);
    @(negedge clk);
    busNum = b; devNum = d; accWrite = w;
    #5;
    check(tag, {26'd0, hit, destNode, destLink}, {26'd0, exp});
  endtask

  task automatic sweep(input bit fullDev);
    for (int b = 0; b < 256; b++) begin
      for (int d = 0; d < 32; d++) begin
        if (fullDev || d == 0 || d == 7 || d == 31) begin
          for (int w = 0; w < 2; w++) begin
            int win = winner(8'(b), 5'(d), w[0]);
            logic [5:0] exp;
            string tag;
            if (win < 0) begin
              exp = '0; tag = "R8";
            end else begin
              exp = {1'b1, shadow[win][6:4], shadow[win][9:8]};
              tag = shadow[win][2] ? "R4" : "R3";
            end
            probe(tag, 8'(b), 5'(d), w[0], exp);
          end
        end
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); regIdx = 2'(i); #5;
      check("R1", regRdata, 32'h0);
    end
    probe("R1", 8'd0, 5'd0, 1'b0, 6'd0);
    probe("R1", 8'd255, 5'd31, 1'b1, 6'd0);

    // R2: single write, others untouched
    wrReg(0, 32'h140A0253);   // bus 10..20, link 2, node 5, rd+wr
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); regIdx = 2'(i); #5;
      check("R2", regRdata, shadow[i]);
    end
    sweep(1'b0);

    wrReg(1, 32'h09030137);   // device mode 3..9, link 1, node 3, rd+wr
    wrReg(2, 32'h280F0372);   // bus 15..40, link 3, node 7, write only
    wrReg(3, 32'h28320013);   // empty window 50..40, node 1, rd+wr
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); regIdx = 2'(i); #5;
      check("R2", regRdata, shadow[i]);
    end

    // directed corner cases
    probe("R3", 8'd10, 5'd0, 1'b0, {1'b1, 3'd5, 2'd2});
    probe("R3", 8'd20, 5'd0, 1'b0, {1'b1, 3'd5, 2'd2});
    probe("R3", 8'd9,  5'd0, 1'b0, 6'd0);
    probe("R7", 8'd15, 5'd0, 1'b1, {1'b1, 3'd5, 2'd2});
    probe("R6", 8'd25, 5'd0, 1'b1, {1'b1, 3'd7, 2'd3});
    probe("R5", 8'd25, 5'd0, 1'b0, 6'd0);
    probe("R4", 8'd0,  5'd5, 1'b0, {1'b1, 3'd3, 2'd1});
    probe("R4", 8'd1,  5'd5, 1'b0, 6'd0);
    probe("R4", 8'd0,  5'd10, 1'b0, 6'd0);
    probe("R9", 8'd45, 5'd0, 1'b0, 6'd0);
    probe("R9", 8'd50, 5'd0, 1'b1, 6'd0);
    probe("R8", 8'd200, 5'd0, 1'b1, 6'd0);

    // exhaustive sweep of the mixed programming
    sweep(1'b1);

    // R2: overwrite one region and confirm its neighbours hold
    wrReg(2, 32'h00000000);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); regIdx = 2'(i); #5;
      check("R2", regRdata, shadow[i]);
    end
    probe("R8", 8'd25, 5'd0, 1'b1, 6'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule